// File: doc/BRIEF.md
# Console Register Display and Entry Datapath

This block sits between an operator console and four machine registers (program counter P, instruction I, buffer B, accumulator A). A two-bit selector picks one register. While the machine is in manual mode, the console is enabled, and the timing phase in which sequencing is held is active, the selected register is gated onto a shared adder bus. The bus drives the console bit lamps, so the lamps show that register.

When A or B is selected, the console bit pushbuttons are placed on the same bus together with the register contents. The bus value is then written back into the selected register. The effect is that pressed bits are ORed into what the register already holds. Pressing the clear pushbutton suppresses the register-to-bus path, so the write-back carries only the buttons. With no buttons held, this empties the register.

The register file itself lives outside this block. The block receives the four register words as inputs. It returns the bus and one write strobe for A and one for B. Every output is registered and appears one clock after the inputs that produce it.

Top module: `conpan_dp`

## Requirements
- R1: While reset is asserted, and on the first edge after it, lamp_bus is zero and wr_a and wr_b are low.
- R2: lamp_bus is zero one clock after any cycle in which man_mode, con_en or hold_phase is low.
- R3: Call a cycle live when man_mode, con_en and hold_phase are all high. One clock after a live cycle with clr_btn low, lamp_bus contains the selected register. The select codes are 2'b00 for P, 2'b01 for I, 2'b10 for B and 2'b11 for A.
- R4: With P or I selected (sel[1] low), the pushbuttons never reach lamp_bus, and wr_a and wr_b stay low.
- R5: One clock after a live cycle with A or B selected, lamp_bus equals the selected register ORed with bit_btn. When clr_btn is high, the register term is zero.
- R6: One clock after a live cycle with clr_btn high, lamp_bus equals bit_btn if A or B is selected, and zero if P or I is selected.
- R7: wr_a (wr_b) pulses for exactly one clock, one clock after the first cycle of a run of live cycles with A (B) selected. It does not pulse again while that run continues. The pulse coincides with the lamp_bus value to be written.
- R8: wr_a and wr_b are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| man_mode | input | 1 | Machine is in manual mode |
| con_en | input | 1 | Console enabled |
| hold_phase | input | 1 | Timing phase in which manual sequencing is held |
| sel | input | 2 | Register select code (00 P, 01 I, 10 B, 11 A) |
| clr_btn | input | 1 | Clear pushbutton |
| bit_btn | input | 24 | Console bit pushbuttons |
| reg_p | input | 24 | Current P register contents |
| reg_i | input | 24 | Current I register contents |
| reg_b | input | 24 | Current B register contents |
| reg_a | input | 24 | Current A register contents |
| lamp_bus | output | 24 | Adder bus, drives indicators and write data |
| wr_a | output | 1 | Write strobe for A, data on lamp_bus |
| wr_b | output | 1 | Write strobe for B, data on lamp_bus |

## Verification
Clearing and merging share one cycle. Clear suppresses the register path while the buttons still OR in, and the write strobe for A or B fires in that same cycle. The bench sweeps every combination of select, clear, mode, enable and phase with the buttons held, under several register and button patterns. It compares lamp_bus and both strobes against a bench model of the OR and clear rule and of the first-live-cycle rule. Held live runs and select changes within a run check that each target receives exactly one strobe per run, carrying the merged or cleared word.

// File: rtl/conpan_pkg.sv
package conpan_pkg;
    typedef enum logic [1:0] {
        SEL_P = 2'b00,
        SEL_I = 2'b01,
        SEL_B = 2'b10,
        SEL_A = 2'b11
    } regsel_e;

    localparam int NUM_SRC = 4;
endpackage

// File: rtl/conpan_src_mux.sv
// One-hot AND-OR selection of the register to be shown.
module conpan_src_mux
    import conpan_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic [1:0]                 sel,
    input  logic [NUM_SRC-1:0][DW-1:0] src,
    output logic [DW-1:0]              word
);
    logic [NUM_SRC-1:0]         hot;
    logic [NUM_SRC-1:0][DW-1:0] gated;

    always_comb begin
        hot = '0;
        hot[sel] = 1'b1;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        assign gated[g] = {DW{hot[g]}} & src[g];
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            word = word | gated[k];
        end
    end
endmodule

// File: rtl/conpan_merge.sv
// Forms the adder bus: read path (suppressed by clear) ORed with buttons.
module conpan_merge #(
    parameter int DW = 24
) (
    input  logic          live,
    input  logic          clr,
    input  logic          writable,
    input  logic [DW-1:0] reg_word,
    input  logic [DW-1:0] btn,
    output logic [DW-1:0] bus_word
);
    logic [DW-1:0] read_path;
    logic [DW-1:0] btn_path;

    assign read_path = clr      ? '0  : reg_word;
    assign btn_path  = writable ? btn : '0;
    assign bus_word  = live ? (read_path | btn_path) : '0;
endmodule

// File: rtl/conpan_dp.sv
module conpan_dp
    import conpan_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          man_mode,
    input  logic          con_en,
    input  logic          hold_phase,
    input  logic [1:0]    sel,
    input  logic          clr_btn,
    input  logic [DW-1:0] bit_btn,
    input  logic [DW-1:0] reg_p,
    input  logic [DW-1:0] reg_i,
    input  logic [DW-1:0] reg_b,
    input  logic [DW-1:0] reg_a,
    output logic [DW-1:0] lamp_bus,
    output logic          wr_a,
    output logic          wr_b
);
    typedef struct packed {
        logic [DW-1:0] bus;
        logic          wr_a;
        logic          wr_b;
        logic          arm_a;
        logic          arm_b;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0][DW-1:0] srcs;
    logic [DW-1:0]              sel_word;
    logic [DW-1:0]              bus_word;
    logic                       live;
    logic                       writable;
    regsel_e                    sel_e;

    assign sel_e    = regsel_e'(sel);
    assign live     = man_mode & con_en & hold_phase;
    assign writable = (sel_e == SEL_A) | (sel_e == SEL_B);

    assign srcs[SEL_P] = reg_p;
    assign srcs[SEL_I] = reg_i;
    assign srcs[SEL_B] = reg_b;
    assign srcs[SEL_A] = reg_a;

    conpan_src_mux #(.DW(DW)) u_mux (
        .sel  (sel),
        .src  (srcs),
        .word (sel_word)
    );

    conpan_merge #(.DW(DW)) u_merge (
        .live     (live),
        .clr      (clr_btn),
        .writable (writable),
        .reg_word (sel_word),
        .btn      (bit_btn),
        .bus_word (bus_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.bus   = bus_word;
        st_d.arm_a = live & (sel_e == SEL_A);
        st_d.arm_b = live & (sel_e == SEL_B);
        st_d.wr_a  = st_d.arm_a & ~st_q.arm_a;
        st_d.wr_b  = st_d.arm_b & ~st_q.arm_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lamp_bus = st_q.bus;
    assign wr_a     = st_q.wr_a;
    assign wr_b     = st_q.wr_b;
endmodule

// File: rtl/conpan_dp_chk.sv
module conpan_dp_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          man_mode,
    input logic          con_en,
    input logic          hold_phase,
    input logic [1:0]    sel,
    input logic          clr_btn,
    input logic [DW-1:0] bit_btn,
    input logic [DW-1:0] reg_a,
    input logic [DW-1:0] lamp_bus,
    input logic          wr_a,
    input logic          wr_b
);
    logic live;
    assign live = man_mode & con_en & hold_phase;

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (lamp_bus == '0));

    a_r4_pi_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !sel[1] |=> (!wr_a && !wr_b));

    a_r5_merge_a: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !clr_btn && sel == 2'b11) |=> (lamp_bus == ($past(reg_a) | $past(bit_btn))));

    a_r6_clear_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (live && clr_btn && sel[1]) |=> (lamp_bus == $past(bit_btn)));

    a_r7_single_pulse_a: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> !wr_a);

    a_r7_single_pulse_b: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> !wr_b);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_a && wr_b));
endmodule

bind conpan_dp conpan_dp_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .man_mode   (man_mode),
    .con_en     (con_en),
    .hold_phase (hold_phase),
    .sel        (sel),
    .clr_btn    (clr_btn),
    .bit_btn    (bit_btn),
    .reg_a      (reg_a),
    .lamp_bus   (lamp_bus),
    .wr_a       (wr_a),
    .wr_b       (wr_b)
);

// File: tb/conpan_dp_test.sv
module conpan_dp_test;
    localparam int DW = 24;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          man_mode = 1'b0, con_en = 1'b0, hold_phase = 1'b0, clr_btn = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic [DW-1:0] bit_btn = '0, reg_p = '0, reg_i = '0, reg_b = '0, reg_a = '0;
    logic [DW-1:0] lamp_bus;
    logic          wr_a, wr_b;

    int checks = 0;
    int errors = 0;
    logic prev_arm_a = 1'b0, prev_arm_b = 1'b0;

    conpan_dp #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .man_mode(man_mode), .con_en(con_en),
        .hold_phase(hold_phase), .sel(sel), .clr_btn(clr_btn), .bit_btn(bit_btn),
        .reg_p(reg_p), .reg_i(reg_i), .reg_b(reg_b), .reg_a(reg_a),
        .lamp_bus(lamp_bus), .wr_a(wr_a), .wr_b(wr_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs already set; clock once, check at the following falling edge.
    task automatic cycle_and_check();
        logic live;
        logic [DW-1:0] rsel, eb;
        logic arm_a, arm_b;
        live = man_mode & con_en & hold_phase;
        case (sel)
            2'b00: rsel = reg_p;
            2'b01: rsel = reg_i;
            2'b10: rsel = reg_b;
            default: rsel = reg_a;
        endcase
        eb = '0;
        if (live) eb = (clr_btn ? '0 : rsel) | (sel[1] ? bit_btn : '0);
        arm_a = live & (sel == 2'b11);
        arm_b = live & (sel == 2'b10);
        @(posedge clk);
        @(negedge clk);
        if (!live)              chk("R2 idle bus", 32'(lamp_bus), 32'(eb));
        else if (clr_btn)       chk("R6 clear bus", 32'(lamp_bus), 32'(eb));
        else if (sel[1])        chk("R5 merge bus", 32'(lamp_bus), 32'(eb));
        else                    chk("R3 R4 display bus", 32'(lamp_bus), 32'(eb));
        chk("R7 wr_a", 32'(wr_a), 32'(arm_a & ~prev_arm_a));
        chk("R7 wr_b", 32'(wr_b), 32'(arm_b & ~prev_arm_b));
        chk("R8 exclusive", 32'(wr_a & wr_b), 32'd0);
        prev_arm_a = arm_a;
        prev_arm_b = arm_b;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        man_mode = 1'b1; con_en = 1'b1; hold_phase = 1'b1; sel = 2'b11;
        bit_btn = 24'hFFFFFF; reg_a = 24'h123456;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset bus", 32'(lamp_bus), 32'd0);
        chk("R1 reset wr_a", 32'(wr_a), 32'd0);
        chk("R1 reset wr_b", 32'(wr_b), 32'd0);
        man_mode = 1'b0;
        rst_n = 1'b1;
        cycle_and_check();

        // Exhaustive sweep of control combinations under several data patterns.
        for (int pat = 0; pat < 6; pat++) begin
            reg_p   = 24'(32'h00A5A5A5 ^ (pat * 32'h00111111));
            reg_i   = 24'(32'h005A5A5A + pat * 32'h00013579);
            reg_b   = 24'(32'h00F0F000 >> pat);
            reg_a   = 24'(32'h00000FF0 << pat);
            bit_btn = (pat == 0) ? '0 : 24'(32'h00800001 | (32'h1 << (pat * 3)));
            for (int c = 0; c < 64; c++) begin
                sel        = 2'(c);
                clr_btn    = c[2];
                man_mode   = c[3];
                con_en     = c[4];
                hold_phase = c[5];
                cycle_and_check();
            end
        end

        // Held live run with A selected: single strobe, then B within the run.
        man_mode = 1'b1; con_en = 1'b1; hold_phase = 1'b0; clr_btn = 1'b0;
        sel = 2'b11; reg_a = 24'h000F00; bit_btn = 24'h800001;
        cycle_and_check();
        hold_phase = 1'b1;
        for (int k = 0; k < 5; k++) cycle_and_check();  // R7 one pulse per run
        sel = 2'b10; reg_b = 24'h0000C0;
        for (int k = 0; k < 3; k++) cycle_and_check();  // R7 B arms on change
        clr_btn = 1'b1; bit_btn = '0;
        cycle_and_check();                              // R6 clear to zero
        sel = 2'b00; bit_btn = 24'hFFFFFF;
        cycle_and_check();                              // R4 P ignores buttons
        clr_btn = 1'b0;
        cycle_and_check();
        hold_phase = 1'b0;
        cycle_and_check();
        hold_phase = 1'b1; sel = 2'b11;
        cycle_and_check();

        // Reset mid-run returns outputs to idle.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset bus mid-run", 32'(lamp_bus), 32'd0);
        chk("R1 reset wr_a mid-run", 32'(wr_a), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule